// File: doc/BRIEF.md
# Window Watchdog with Fault Escalation

This block supervises a host that must prove it is alive by pulling a kick line low at regular intervals. A glitch filter cleans the kick line first. The falling edges that survive are then checked against a timing window counted in clock cycles. A missing kick or a kick that arrives too early is a fault. A fault drives an active-low reset pulse of programmable length. While the supply-good level is low, the block holds reset asserted. Reset is also held for one programmed reset period after the supply returns.

Faults also feed an escalation path. Three faults in a row assert a sticky, active-low enable-kill output. That output clears only after the host delivers three good kicks in a row. Enable-kill is never driven active while the supply-good input is low. A mode input selects between a plain timeout watchdog and a window watchdog. In window mode the closed part of the window is either one half or three quarters of the timeout. A timeout value of zero switches the watchdog off.

Top module: `kick_guard`

## Requirements
- R1: While `rst_n` is low, `reset_n_out` is 0 and `enable_n_out` is 1.
- R2: While `supply_ok` is low, `reset_n_out` is 0 from the next clock edge. After `supply_ok` returns high, `reset_n_out` goes to 1 on the `reset_cycles`-th rising edge at which `supply_ok` is sampled high. A value of 0 in `reset_cycles` counts as 1. Leaving `rst_n` behaves the same way.
- R3: With no accepted kick, a fault occurs on the `timeout_cycles`-th rising edge after `reset_n_out` goes high. A free-running block therefore shows reset high for `timeout_cycles` cycles and low for `reset_cycles` cycles, repeating.
- R4: Every fault drives `reset_n_out` low for exactly `reset_cycles` cycles, after which it returns high.
- R5: When `window_mode`=1, an accepted kick is a fault if it arrives before the closed time. The closed time is floor(T/2) when `closed_sel`=0, or floor(T/2)+floor(T/4) when `closed_sel`=1. When `window_mode`=0, no kick is ever a fault.
- R6: Every accepted kick while reset is high restarts the timeout count. The count is held at zero while reset is asserted, and kicks during reset are ignored.
- R7: On the third consecutive fault, `enable_n_out` goes low one cycle after the fault. It stays low across later supply-good recoveries until R8 is met.
- R8: Once `enable_n_out` is low, it returns high only after three consecutive good kicks.
- R9: A good kick clears the fault streak, and a fault clears the good-kick streak. Two faults, then a good kick, then two more faults leave `enable_n_out` high.
- R10: While `supply_ok` is low, `enable_n_out` is 1 from the next clock edge.
- R11: A low pulse on `kick_in` shorter than `FILT_CYCLES` cycles is ignored. A low level held for at least `FILT_CYCLES`+2 cycles is accepted as a kick about `FILT_CYCLES`+3 cycles after the falling edge.
- R12: With `timeout_cycles`=0, no fault ever occurs: reset follows only `supply_ok`, and `enable_n_out` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick_in | input | 1 | Kick line from the host; falling edges are kicks |
| supply_ok | input | 1 | Supply-good level |
| window_mode | input | 1 | 0 = plain timeout, 1 = window check |
| closed_sel | input | 1 | Closed window: 0 = half, 1 = three quarters of the timeout |
| timeout_cycles | input | CW | Timeout in cycles; 0 disables the watchdog |
| reset_cycles | input | CW | Length of the reset pulse in cycles |
| reset_n_out | output | 1 | Active-low reset to the host |
| enable_n_out | output | 1 | Active-low sticky enable-kill |

## Verification
Kick timing is exercised in three classes: early kicks inside the closed window, kicks well inside the open window, and no kick at all. These tell an early-kick fault, a good kick and a timeout fault apart in both modes and for both closed fractions. Each kick is placed well clear of either window edge, so the filter latency does not blur the class. Directed sequences measure exact pulse and period lengths. They also check fault and good-kick streaks, including a broken streak, and compare two-cycle glitches against wide pulses. Further sequences cover supply loss while enable-kill is set, and operation with the watchdog disabled.

// File: rtl/kick_guard.sv
`timescale 1ns/1ps
module kick_guard #(
  parameter int CW          = 16,
  parameter int FILT_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick_in,
  input  logic          supply_ok,
  input  logic          window_mode,
  input  logic          closed_sel,
  input  logic [CW-1:0] timeout_cycles,
  input  logic [CW-1:0] reset_cycles,
  output logic          reset_n_out,
  output logic          enable_n_out
);
  localparam int FW = $clog2(FILT_CYCLES + 1);

  logic          k_s1, k_s2, k_f, k_fd;
  logic [FW-1:0] fcnt;
  logic          in_rst;
  logic [CW-1:0] rcnt, wcnt;
  logic [1:0]    bad_cnt, good_cnt;
  logic          kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_s1 <= 1'b1; k_s2 <= 1'b1; k_f <= 1'b1; k_fd <= 1'b1; fcnt <= '0;
    end else begin
      k_s1 <= kick_in;
      k_s2 <= k_s1;
      k_fd <= k_f;
      if (k_s2 == k_f) fcnt <= '0;
      else if (fcnt == FW'(FILT_CYCLES - 1)) begin
        k_f  <= k_s2;
        fcnt <= '0;
      end else fcnt <= fcnt + 1'b1;
    end
  end

  wire          kick_ev = k_fd & ~k_f;
  wire          wd_on   = (timeout_cycles != '0);
  wire          running = wd_on & ~in_rst;
  wire [CW-1:0] closed  = !window_mode ? '0 :
                          closed_sel ? (timeout_cycles >> 1) + (timeout_cycles >> 2)
                                     : (timeout_cycles >> 1);
  wire          early   = kick_ev & (wcnt < closed);
  wire          expire  = (wcnt == timeout_cycles - 1'b1);
  wire          fault   = running & (kick_ev ? early : expire);
  wire          good    = running & kick_ev & ~early;
  wire [CW-1:0] rlim    = (reset_cycles == '0) ? CW'(1) : reset_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_rst <= 1'b1;
      rcnt   <= '0;
    end else if (!supply_ok || fault) begin
      in_rst <= 1'b1;
      rcnt   <= '0;
    end else if (in_rst) begin
      if ({1'b0, rcnt} + 1'b1 >= {1'b0, rlim}) begin
        in_rst <= 1'b0;
        rcnt   <= '0;
      end else rcnt <= rcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt <= '0;
    else if (!running || kick_ev) wcnt <= '0;
    else wcnt <= wcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_cnt <= '0; good_cnt <= '0; kill <= 1'b0;
    end else if (!wd_on) begin
      bad_cnt <= '0; good_cnt <= '0; kill <= 1'b0;
    end else if (fault) begin
      good_cnt <= '0;
      bad_cnt  <= (bad_cnt == 2'd3) ? 2'd3 : bad_cnt + 1'b1;
      if (bad_cnt >= 2'd2 && supply_ok) kill <= 1'b1;
    end else if (good) begin
      bad_cnt  <= '0;
      good_cnt <= (good_cnt == 2'd3) ? 2'd3 : good_cnt + 1'b1;
      if (good_cnt >= 2'd2) kill <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enable_n_out <= 1'b1;
    else enable_n_out <= ~(kill & supply_ok);
  end

  assign reset_n_out = ~in_rst;

  assert_supply_holds_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !reset_n_out);
  assert_fault_pulls_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!reset_n_out && rcnt == '0));
  assert_timer_idle_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_rst |=> (wcnt == '0));
  assert_kill_after_three_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kill) |-> (bad_cnt == 2'd3));
  assert_streaks_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bad_cnt != 2'd0 && good_cnt != 2'd0));
  assert_no_kill_low_supply_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> enable_n_out);
  assert_disabled_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_cycles == '0 && $past(timeout_cycles == '0)) |=> enable_n_out);
endmodule

// File: tb/kick_guard_bench.sv
`timescale 1ns/1ps
module kick_guard_bench;
  localparam int CW = 16;
  localparam int FILT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kick_in = 1'b1;
  logic supply_ok = 1'b1;
  logic window_mode = 1'b0;
  logic closed_sel = 1'b0;
  logic [CW-1:0] tmo = 16'd100;
  logic [CW-1:0] rsl = 16'd10;
  logic reset_n_out, enable_n_out;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  kick_guard #(.CW(CW), .FILT_CYCLES(FILT)) u_kick_guard (
    .clk(clk), .rst_n(rst_n), .kick_in(kick_in), .supply_ok(supply_ok),
    .window_mode(window_mode), .closed_sel(closed_sel),
    .timeout_cycles(tmo), .reset_cycles(rsl),
    .reset_n_out(reset_n_out), .enable_n_out(enable_n_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edges_until(input logic lvl, input int maxc, output int n);
    n = 0;
    do begin
      @(posedge clk); #2; n++;
    end while (reset_n_out !== lvl && n < maxc);
  endtask

  task automatic count_lows(input int n, inout int lows);
    repeat (n) begin
      @(negedge clk);
      if (!reset_n_out) lows++;
    end
  endtask

  task automatic kick_watch(input int len, input int after, output int lows);
    lows = 0;
    @(negedge clk);
    kick_in = 1'b0;
    count_lows(len, lows);
    kick_in = 1'b1;
    count_lows(after, lows);
  endtask

  task automatic hard_reset(input int t, input int r, input bit w, input bit s);
    @(negedge clk);
    rst_n = 1'b0;
    tmo = CW'(t); rsl = CW'(r); window_mode = w; closed_sel = s;
    cyc(2);
    rst_n = 1'b1;
  endtask

  task automatic restart(input int t, input int r, input bit w, input bit s);
    int n;
    @(negedge clk);
    supply_ok = 1'b0;
    cyc(1);
    tmo = CW'(t); rsl = CW'(r); window_mode = w; closed_sel = s;
    cyc(2);
    supply_ok = 1'b1;
    edges_until(1'b1, 5000, n);
  endtask

  function automatic int closed_of(input int t, input bit w, input bit s);
    if (!w) return 0;
    return s ? (t / 2 + t / 4) : t / 2;
  endfunction

  function automatic bit predict_fault(input int t, input bit w, input bit s, input int eff);
    return w && (eff < closed_of(t, w, s));
  endfunction

  initial begin
    #(20ns * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, lows;
    // R1 reset state
    cyc(3);
    chk(reset_n_out === 1'b0, "R1 reset_n_out in reset", reset_n_out, 0);
    chk(enable_n_out === 1'b1, "R1 enable_n_out in reset", enable_n_out, 1);
    rst_n = 1'b1;
    edges_until(1'b1, 5000, n);
    chk(n == 10, "R2 release after rst_n", n, 10);

    // R2 supply hold and release length
    @(negedge clk); supply_ok = 1'b0; rsl = 16'd12;
    cyc(5);
    chk(reset_n_out === 1'b0, "R2 held while supply low", reset_n_out, 0);
    supply_ok = 1'b1;
    edges_until(1'b1, 5000, n);
    chk(n == 12, "R2 release count", n, 12);

    // R3/R4 free-running period
    edges_until(1'b0, 5000, n);
    chk(n == 100, "R3 timeout to fault", n, 100);
    edges_until(1'b1, 5000, n);
    chk(n == 12, "R4 fault pulse length", n, 12);
    edges_until(1'b0, 5000, n);
    chk(n == 100, "R3 second period", n, 100);

    // R7 three strikes, R8 recovery, R6 kicks restart timer
    hard_reset(100, 10, 1'b0, 1'b0);
    edges_until(1'b1, 5000, n); edges_until(1'b0, 5000, n);
    edges_until(1'b1, 5000, n); edges_until(1'b0, 5000, n);
    cyc(3);
    chk(enable_n_out === 1'b1, "R7 still high after two faults", enable_n_out, 1);
    edges_until(1'b1, 5000, n); edges_until(1'b0, 5000, n);
    cyc(3);
    chk(enable_n_out === 1'b0, "R7 low after third fault", enable_n_out, 0);
    edges_until(1'b1, 5000, n);
    for (int i = 0; i < 3; i++) begin
      cyc(40);
      kick_watch(10, 10, lows);
      chk(lows == 0, "R6 good kick keeps reset high", lows, 0);
      if (i == 1) chk(enable_n_out === 1'b0, "R8 low after two good kicks", enable_n_out, 0);
      if (i == 2) chk(enable_n_out === 1'b1, "R8 high after three good kicks", enable_n_out, 1);
    end
    lows = 0;
    for (int i = 0; i < 4; i++) begin
      cyc(40);
      kick_watch(10, 10, n);
      lows += n;
    end
    chk(lows == 0, "R6 repeated kicks span several timeouts", lows, 0);

    // R9 broken streak, then R7 kill, then R10 supply
    hard_reset(100, 10, 1'b0, 1'b0);
    edges_until(1'b1, 5000, n); edges_until(1'b0, 5000, n);
    edges_until(1'b1, 5000, n); edges_until(1'b0, 5000, n);
    edges_until(1'b1, 5000, n);
    cyc(40);
    kick_watch(10, 10, lows);
    edges_until(1'b0, 5000, n); edges_until(1'b1, 5000, n); edges_until(1'b0, 5000, n);
    cyc(3);
    chk(enable_n_out === 1'b1, "R9 streak broken by good kick", enable_n_out, 1);
    edges_until(1'b1, 5000, n); edges_until(1'b0, 5000, n);
    cyc(3);
    chk(enable_n_out === 1'b0, "R9 third fault of new streak kills", enable_n_out, 0);
    supply_ok = 1'b0;
    cyc(1);
    chk(enable_n_out === 1'b1, "R10 enable released on low supply", enable_n_out, 1);
    chk(reset_n_out === 1'b0, "R2 reset on low supply", reset_n_out, 0);
    cyc(5);
    supply_ok = 1'b1;
    cyc(2);
    chk(enable_n_out === 1'b0, "R7 kill sticky over supply loss", enable_n_out, 0);

    // R5 closed fraction and mode
    restart(200, 10, 1'b1, 1'b0);
    cyc(115);
    kick_watch(10, 20, lows);
    chk(lows == 0, "R5 half window accepts kick", lows, 0);
    restart(200, 10, 1'b1, 1'b1);
    cyc(115);
    kick_watch(10, 20, lows);
    chk(lows > 0, "R5 three-quarter window rejects kick", lows, 1);
    restart(200, 10, 1'b0, 1'b1);
    cyc(20);
    kick_watch(10, 20, lows);
    chk(lows == 0, "R5 timeout mode accepts early kick", lows, 0);

    // R11 glitch filter
    restart(200, 10, 1'b1, 1'b1);
    cyc(20);
    kick_watch(2, 40, lows);
    chk(lows == 0, "R11 short pulse ignored", lows, 0);
    kick_watch(10, 20, lows);
    chk(lows > 0, "R11 wide pulse accepted (early fault)", lows, 1);

    // R12 disabled
    restart(0, 10, 1'b1, 1'b1);
    lows = 0;
    count_lows(1000, lows);
    chk(lows == 0, "R12 no faults when disabled", lows, 0);
    chk(enable_n_out === 1'b1, "R12 enable stays high", enable_n_out, 1);

    // constrained random trials, R3 and R5
    void'($urandom(32'h5eed_1234));
    for (int tr = 0; tr < 40; tr++) begin
      int t, r, cls, c, lo, hi, eff;
      bit w, s, expf;
      t = 120 + int'($urandom % 281);
      r = 4 + int'($urandom % 27);
      w = 1'($urandom % 2);
      s = 1'($urandom % 2);
      cls = int'($urandom % 3);
      c = closed_of(t, w, s);
      restart(t, r, w, s);
      if (cls == 2) begin
        lows = 0;
        count_lows(t + 20, lows);
        chk(lows > 0, "R3 random no-kick timeout", lows, 1);
      end else begin
        if (cls == 0 && w) begin lo = 10; hi = c - 15; end
        else begin lo = c + 15; hi = t - 15; end
        if (lo < 10) lo = 10;
        eff = lo + int'($urandom % (hi - lo + 1));
        expf = predict_fault(t, w, s, eff);
        cyc(eff - 8);
        kick_watch(10, 20, lows);
        chk((lows > 0) == expf, "R5 random kick classification", lows, expf);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule